// File: doc/BRIEF.md
# Fetch-to-Dispatch Instruction Queue

This block is a twelve-entry circular instruction buffer placed between the fetch stage and the dispatch stage of a superscalar front end. Each cycle, fetch can append up to four 32-bit instruction words taken from a 128-bit bundle. In the same cycle, dispatch can retire up to three of the oldest words, which the block presents as a 96-bit bundle. Program order is kept across the whole path.

Fetch states how many lanes of its bundle carry instructions. Dispatch states how many of the presented words it consumed. The block registers its free-slot count so that fetch sees a stable value throughout each cycle. A flush, raised on a redirect, empties the queue in a single cycle.

Top module: `instrQueue`

## Requirements
- R1: After reset the queue is empty: `freeSlots` = 12, `rdValidCount` = 0 and `rdBundle` = 0.
- R2: Fetch writes the first `wrCount` lanes of `wrBundle`, where lane i occupies bits [32i+31:32i] and lane 0 is the oldest. These words are appended behind the existing contents in lane order.
- R3: The number of words accepted is the smallest of `wrCount` (capped at 4) and the room left after this cycle's removals. Any excess youngest lanes are dropped, and occupancy never exceeds 12.
- R4: Output lane j of `rdBundle` (bits [32j+31:32j]) holds the j-th oldest word. `rdValidCount` equals the smaller of the occupancy and 3.
- R5: Output lanes at or above `rdValidCount` read as zero.
- R6: `rdTaken` removes that many of the oldest words, clipped to `rdValidCount`. Any words not taken stay at the head in their original order.
- R7: A read and a write in the same cycle are both applied. Space freed by that cycle's removal is available to that cycle's write.
- R8: `flush` empties the queue at the next clock edge and overrides both the write and the take in that cycle.
- R9: `freeSlots` is a register equal to 12 minus the occupancy. It changes only at the clock edge where the occupancy changes.
- R10: Program order is preserved when the storage index wraps past its last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue |
| wrCount | input | 3 | Number of fetch lanes being written (0..4) |
| wrBundle | input | 128 | Four instruction lanes from fetch |
| rdTaken | input | 2 | Number of words consumed by dispatch (0..3) |
| rdBundle | output | 96 | Three oldest words, lane 0 oldest |
| rdValidCount | output | 2 | Number of valid output lanes |
| freeSlots | output | 4 | Registered count of free entries |

## Verification
Dispatch removal and fetch append can both occur in the same cycle, and a flush can fall on top of either one. The bench provokes the combined case directly by presenting a full queue that takes three words while fetch offers four; exactly three must be accepted. It also drives flush together with a write and a take, after which the queue must come out empty. A behavioural queue model then runs through a long random mix of writes, takes and occasional flushes, including over-requests on both sides. Every cycle, the model's head words, valid count and free count are compared against the outputs.

// File: rtl/iqPkg.sv
package iqPkg;
  parameter int IQ_DEPTH    = 12;
  parameter int IQ_WR_LANES = 4;
  parameter int IQ_RD_LANES = 3;
  parameter int IQ_WORD_W   = 32;
  localparam int IQ_PTR_W   = $clog2(IQ_DEPTH);
  localparam int IQ_CNT_W   = $clog2(IQ_DEPTH + 1);

  typedef struct packed {
    logic                    flush;
    logic [IQ_WR_LANES-1:0]  wrLaneEn;
    logic [IQ_PTR_W-1:0]     wrBase;
    logic [IQ_PTR_W-1:0]     rdBase;
    logic [IQ_RD_LANES-1:0]  rdLaneValid;
  } iqStrobes_t;

  // Circular pointer advance; step never exceeds depth
  function automatic logic [IQ_PTR_W-1:0] ptrAdvance(input logic [IQ_PTR_W-1:0] ptr, input int step);
    int sum;
    sum = int'(ptr) + step;
    if (sum >= IQ_DEPTH) sum = sum - IQ_DEPTH;
    return IQ_PTR_W'(sum);
  endfunction
endpackage

// File: rtl/iqCtrl.sv
module iqCtrl
  import iqPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     flush,
  input  logic [2:0]               wrCount,
  input  logic [1:0]               rdTaken,
  output iqStrobes_t               strobes,
  output logic [1:0]               rdValidCount,
  output logic [IQ_CNT_W-1:0]      freeSlots
);
  logic [IQ_PTR_W-1:0] headPtr, tailPtr;
  logic [IQ_CNT_W-1:0] occ;
  int validN, takeN, roomN, reqN, acceptN, occNext;

  always_comb begin
    validN  = (int'(occ) > IQ_RD_LANES) ? IQ_RD_LANES : int'(occ);
    takeN   = (int'(rdTaken) > validN) ? validN : int'(rdTaken);
    roomN   = IQ_DEPTH - int'(occ) + takeN;
    reqN    = (int'(wrCount) > IQ_WR_LANES) ? IQ_WR_LANES : int'(wrCount);
    acceptN = (reqN > roomN) ? roomN : reqN;
    occNext = int'(occ) - takeN + acceptN;
  end

  always_comb begin
    strobes.flush  = flush;
    strobes.wrBase = tailPtr;
    strobes.rdBase = headPtr;
  end

  for (genvar i = 0; i < IQ_WR_LANES; i++) begin : g_wrEn
    assign strobes.wrLaneEn[i] = !flush && (i < acceptN);
  end
  for (genvar j = 0; j < IQ_RD_LANES; j++) begin : g_rdVal
    assign strobes.rdLaneValid[j] = (j < validN);
  end

  assign rdValidCount = 2'(validN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      occ       <= '0;
      freeSlots <= IQ_CNT_W'(IQ_DEPTH);
    end else if (flush) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      occ       <= '0;
      freeSlots <= IQ_CNT_W'(IQ_DEPTH);
    end else begin
      headPtr   <= ptrAdvance(headPtr, takeN);
      tailPtr   <= ptrAdvance(tailPtr, acceptN);
      occ       <= IQ_CNT_W'(occNext);
      freeSlots <= IQ_CNT_W'(IQ_DEPTH - occNext);
    end
  end
endmodule

// File: rtl/iqData.sv
module iqData
  import iqPkg::*;
(
  input  logic                              clk,
  input  iqStrobes_t                        strobes,
  input  logic [IQ_WR_LANES*IQ_WORD_W-1:0]  wrBundle,
  output logic [IQ_RD_LANES*IQ_WORD_W-1:0]  rdBundle
);
  logic [IQ_WORD_W-1:0] mem [IQ_DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < IQ_WR_LANES; i++) begin
      if (!strobes.flush && strobes.wrLaneEn[i])
        mem[ptrAdvance(strobes.wrBase, i)] <= wrBundle[i*IQ_WORD_W +: IQ_WORD_W];
    end
  end

  for (genvar j = 0; j < IQ_RD_LANES; j++) begin : g_rdLane
    assign rdBundle[j*IQ_WORD_W +: IQ_WORD_W] =
      strobes.rdLaneValid[j] ? mem[ptrAdvance(strobes.rdBase, j)] : '0;
  end
endmodule

// File: rtl/instrQueue.sv
module instrQueue
  import iqPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic [2:0]    wrCount,
  input  logic [127:0]  wrBundle,
  input  logic [1:0]    rdTaken,
  output logic [95:0]   rdBundle,
  output logic [1:0]    rdValidCount,
  output logic [3:0]    freeSlots
);
  iqStrobes_t strobes;

  iqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .wrCount(wrCount), .rdTaken(rdTaken),
    .strobes(strobes), .rdValidCount(rdValidCount), .freeSlots(freeSlots)
  );

  iqData u_data (
    .clk(clk), .strobes(strobes), .wrBundle(wrBundle), .rdBundle(rdBundle)
  );
endmodule

// File: rtl/iqChecker.sv
module iqChecker (
  input logic          clk,
  input logic          rstN,
  input logic          flush,
  input logic [2:0]    wrCount,
  input logic [1:0]    rdTaken,
  input logic [95:0]   rdBundle,
  input logic [1:0]    rdValidCount,
  input logic [3:0]    freeSlots
);
  logic [3:0] occView;
  logic [1:0] minView;
  assign occView = 4'(12 - int'(freeSlots));
  assign minView = (occView > 4'd3) ? 2'd3 : occView[1:0];

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN) freeSlots <= 4'd12);
  assert_valid_count_R4: assert property (@(posedge clk) disable iff (!rstN) rdValidCount == minView);
  assert_zero_lanes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdValidCount == 2'd1) |-> (rdBundle[95:32] == '0));
  assert_partial_take_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && rdTaken == 2'd1 && rdValidCount >= 2'd2 && wrCount == 3'd0) |=>
      (rdBundle[31:0] == $past(rdBundle[63:32])));
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (freeSlots == 4'd12 && rdValidCount == 2'd0));
  assert_free_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && wrCount == 3'd0 && rdTaken == 2'd0) |=> ($stable(freeSlots) && $stable(rdBundle)));
endmodule

bind instrQueue iqChecker u_iqChecker (
  .clk(clk), .rstN(rstN), .flush(flush), .wrCount(wrCount), .rdTaken(rdTaken),
  .rdBundle(rdBundle), .rdValidCount(rdValidCount), .freeSlots(freeSlots)
);

// File: tb/test_instrQueue.sv
module test_instrQueue;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         flush = 1'b0;
  logic [2:0]   wrCount = '0;
  logic [127:0] wrBundle = '0;
  logic [1:0]   rdTaken = '0;
  logic [95:0]  rdBundle;
  logic [1:0]   rdValidCount;
  logic [3:0]   freeSlots;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  logic [31:0] model[$];
  int unsigned seqWord = 32'h1000;

  always #2.5 clk = ~clk;

  instrQueue i_instrQueue (
    .clk(clk), .rstN(rstN), .flush(flush), .wrCount(wrCount), .wrBundle(wrBundle),
    .rdTaken(rdTaken), .rdBundle(rdBundle), .rdValidCount(rdValidCount), .freeSlots(freeSlots)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic checkOutputs(input string tag);
    logic [95:0] expBundle;
    int expValid;
    expValid = (model.size() > 3) ? 3 : model.size();
    expBundle = '0;
    for (int j = 0; j < expValid; j++) expBundle[j*32 +: 32] = model[j];
    checks++;
    if (int'(freeSlots) != 12 - model.size()) begin
      failures++;
      $display("FAIL %s freeSlots actual=%0d expected=%0d", tag, freeSlots, 12 - model.size());
    end
    checks++;
    if (int'(rdValidCount) != expValid) begin
      failures++;
      $display("FAIL %s rdValidCount actual=%0d expected=%0d", tag, rdValidCount, expValid);
    end
    checks++;
    if (rdBundle !== expBundle) begin
      failures++;
      $display("FAIL %s rdBundle actual=%h expected=%h", tag, rdBundle, expBundle);
    end
  endtask

  // Drive one cycle at the falling edge, update the model, check after the edge
  task automatic step(input bit fl, input int wc, input int rt, input string tag);
    logic [127:0] b;
    int valid, take, room, req, acc;
    for (int i = 0; i < 4; i++) begin
      b[i*32 +: 32] = seqWord;
      seqWord++;
    end
    flush = fl; wrCount = 3'(wc); rdTaken = 2'(rt); wrBundle = b;
    if (fl) model.delete();
    else begin
      valid = (model.size() > 3) ? 3 : model.size();
      take = (rt > valid) ? valid : rt;
      for (int k = 0; k < take; k++) void'(model.pop_front());
      room = 12 - model.size();
      req = (wc > 4) ? 4 : wc;
      acc = (req > room) ? room : req;
      for (int i = 0; i < acc; i++) model.push_back(b[i*32 +: 32]);
    end
    @(posedge clk);
    @(negedge clk);
    flush = 0; wrCount = '0; rdTaken = '0;
    checkOutputs(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkOutputs("R1");
    step(0, 1, 0, "R5");       // one word: lanes 1..2 zero
    step(0, 4, 0, "R2");
    step(0, 4, 0, "R2");
    step(0, 3, 0, "R3");       // reaches full
    step(0, 4, 0, "R3");       // full, all dropped
    step(0, 0, 1, "R6");
    step(0, 0, 0, "R9");       // idle: free count holds
    step(0, 4, 3, "R7");       // free 1 + 3 taken -> 4 accepted
    step(0, 7, 3, "R7");       // over-request clipped to 4 lanes
    step(0, 0, 2, "R4");
    step(1, 4, 3, "R8");       // flush beats write and take
    step(0, 1, 0, "R6");
    step(0, 0, 3, "R6");       // take clipped to 1
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 2, $urandom_range(0, 5), $urandom_range(0, 3), "R10");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule